// File: doc/BRIEF.md
# Fixed-Price Vending Credit Controller

This block is the sequencing core of a single-item vending unit. The item costs fifteen cents. A coin sensor gives one single-cycle pulse per coin, on one pin for a nickel and on another for a dime. The controller keeps the credit paid so far in a small state register, which holds zero, five or ten cents.

On the clock cycle of the coin that reaches or passes the price, two pulses are decoded combinationally from the present credit and the coin inputs. One pulse dispenses the item. The other drops one nickel of change, which happens only when a dime is paid on top of ten cents. At the next clock edge the credit returns to zero. When both coin pins are high together, which no real sensor produces, the block treats the cycle as having no coin.

The state register uses a 2-bit binary code. The unused code leads back to zero credit, so the register cannot lock up. Reset is synchronous and active high.

Top module: `vend_ctrl`

## Requirements
- R1: After reset the credit is zero cents. With no coin, vend_out and change_out are both 0, and a following dime gives no output.
- R2: A cycle with nickel_in=0 and dime_in=0 keeps the credit unchanged and drives both outputs to 0.
- R3: From zero credit, a nickel moves the credit to five and a dime moves it to ten. Both outputs stay 0.
- R4: From five cents, a nickel moves the credit to ten with both outputs 0. A dime drives vend_out=1 and change_out=0 in that cycle, and the credit becomes zero.
- R5: From ten cents, a nickel drives vend_out=1 and change_out=0 in that cycle, and the credit becomes zero.
- R6: From ten cents, a dime drives vend_out=1 and change_out=1 in that cycle, and the credit becomes zero. change_out is never 1 without vend_out.
- R7: nickel_in=1 together with dime_in=1 acts as no coin: the credit is held and both outputs are 0.
- R8: The outputs depend on the present credit and the inputs of the same cycle. They last one cycle only: with no coin on the following cycle, both outputs are 0.
- R9: rst=1 at a clock edge forces the credit to zero, including in the middle of a purchase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_in | input | 1 | One-cycle pulse: a nickel was inserted |
| dime_in | input | 1 | One-cycle pulse: a dime was inserted |
| vend_out | output | 1 | Dispense the item (combinational, one cycle) |
| change_out | output | 1 | Return one nickel (combinational, one cycle) |

## Verification
The credit cannot be read at the ports. Each hidden level therefore has to be reached by a particular sequence of coins, and then confirmed by the coin that finishes the sale. The hardest case is the change path: it needs ten cents of credit, reached either by one dime or by two nickels, and then a dime. The stimulus takes both routes. It also places idle cycles and simultaneous-pin cycles between coins, and asserts reset with credit pending. A behavioural model compares both outputs on every cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Credit held between coins, in nickel units; code 2'b11 is unused.
  typedef enum logic [1:0] {
    CR_ZERO = 2'b00,
    CR_FIVE = 2'b01,
    CR_TEN  = 2'b10,
    CR_VOID = 2'b11
  } credit_e;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'b00,
    COIN_NICKEL = 2'b01,
    COIN_DIME   = 2'b10
  } coin_e;

  typedef struct packed {
    logic vend;
    logic change;
  } sale_t;

  // Credit after one cycle.
  function automatic credit_e credit_step(credit_e cur, coin_e coin);
    credit_e nxt;
    nxt = cur;
    unique case (cur)
      CR_ZERO: begin
        if (coin == COIN_NICKEL) nxt = CR_FIVE;
        else if (coin == COIN_DIME) nxt = CR_TEN;
      end
      CR_FIVE: begin
        if (coin == COIN_NICKEL) nxt = CR_TEN;
        else if (coin == COIN_DIME) nxt = CR_ZERO;
      end
      CR_TEN: begin
        if (coin != COIN_NONE) nxt = CR_ZERO;
      end
      default: nxt = CR_ZERO;
    endcase
    return nxt;
  endfunction

  // Mealy outputs for one cycle.
  function automatic sale_t sale_decode(credit_e cur, coin_e coin);
    sale_t s;
    s = '0;
    unique case (cur)
      CR_FIVE: s.vend = (coin == COIN_DIME);
      CR_TEN: begin
        s.vend   = (coin != COIN_NONE);
        s.change = (coin == COIN_DIME);
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic  nickel_i,
  input  logic  dime_i,
  output coin_e coin_o,
  output logic  clash_o
);
  assign clash_o = nickel_i & dime_i;

  always_comb begin
    if (clash_o)       coin_o = COIN_NONE;
    else if (nickel_i) coin_o = COIN_NICKEL;
    else if (dime_i)   coin_o = COIN_DIME;
    else               coin_o = COIN_NONE;
  end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  credit_e next_i,
  output credit_e cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= CR_ZERO;
    else     cur_o <= next_i;
  end

  assert_reset_zero_R9: assert property (@(posedge clk) rst |=> cur_o == CR_ZERO);
endmodule

// File: rtl/vend_step_logic.sv
module vend_step_logic
  import vend_pkg::*;
(
  input  credit_e cur_i,
  input  coin_e   coin_i,
  output credit_e next_o,
  output sale_t   sale_o
);
  assign next_o = credit_step(cur_i, coin_i);
  assign sale_o = sale_decode(cur_i, coin_i);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nickel_in,
  input  logic dime_in,
  output logic vend_out,
  output logic change_out
);
  coin_e   coin_w;
  logic    clash_w;
  credit_e credit_w;
  credit_e credit_nx_w;
  sale_t   sale_w;

  vend_coin_decode u_dec (
    .nickel_i(nickel_in),
    .dime_i  (dime_in),
    .coin_o  (coin_w),
    .clash_o (clash_w)
  );

  vend_step_logic u_step (
    .cur_i (credit_w),
    .coin_i(coin_w),
    .next_o(credit_nx_w),
    .sale_o(sale_w)
  );

  vend_credit_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .next_i(credit_nx_w),
    .cur_o (credit_w)
  );

  assign vend_out   = sale_w.vend;
  assign change_out = sale_w.change;

  assert_change_with_vend_R6: assert property (@(posedge clk) disable iff (rst)
    change_out |-> vend_out);
  assert_vend_clears_R4: assert property (@(posedge clk) disable iff (rst)
    vend_out |=> credit_w == CR_ZERO);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!nickel_in && !dime_in) |=> $stable(credit_w));
  assert_clash_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    clash_w |-> (!vend_out && !change_out));
endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_in = 1'b0;
  logic dime_in = 1'b0;
  logic vend_out, change_out;
  int   checks = 0;
  int   bad = 0;
  int   credit = 0;   // model credit in cents
  bit   done = 1'b0;

  always #4 clk = ~clk;

  vend_ctrl dut (.clk(clk), .rst(rst), .nickel_in(nickel_in), .dime_in(dime_in),
                 .vend_out(vend_out), .change_out(change_out));

  // One cycle: drive, check outputs before the edge, then advance the model.
  task automatic step(input bit n, input bit d, input string tag);
    int coin;
    bit ev, ec;
    @(negedge clk);
    nickel_in = n;
    dime_in = d;
    #1;
    coin = (n && !d) ? 5 : ((d && !n) ? 10 : 0);
    ev = (credit + coin >= 15);
    ec = (credit + coin > 15);
    checks++;
    if (vend_out !== ev || change_out !== ec) begin
      bad++;
      $display("FAIL %s credit=%0d coin=%0d got RC=%b%b expected RC=%b%b",
               tag, credit, coin, vend_out, change_out, ev, ec);
    end
    @(posedge clk);
    credit = ev ? 0 : credit + coin;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    nickel_in = 1'b0;
    dime_in = 1'b0;
    @(posedge clk);
    credit = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0, 0, "R1 reset idle");
    step(0, 1, "R1 dime after reset");
    step(0, 0, "R2 idle at ten");
    step(0, 0, "R2 idle again");
    step(1, 0, "R5 nickel from ten");
    step(0, 0, "R8 pulse ends");
    step(1, 0, "R3 nickel from zero");
    step(0, 1, "R4 dime from five");
    step(0, 0, "R8 after sale");
    step(1, 0, "R3 nickel");
    step(1, 0, "R4 nickel from five");
    step(0, 1, "R6 dime from ten via nickels");
    step(0, 0, "R8 change pulse ends");
    step(0, 1, "R3 dime from zero");
    step(1, 1, "R7 clash at ten");
    step(0, 1, "R6 dime from ten");
    step(1, 1, "R7 clash at zero");
    step(1, 0, "R3 nickel");
    step(1, 1, "R7 clash at five");
    step(1, 0, "R4 nickel to ten");
    step(1, 0, "R5 nickel from ten");
    step(1, 0, "R3 nickel");
    step(1, 0, "R4 nickel");
    do_reset();
    step(1, 0, "R9 reset mid purchase nickel");
    step(1, 0, "R9 nickel");
    step(1, 0, "R9 sale after reset");
    for (int i = 0; i < 40; i++) step(i % 3 == 0, i % 4 == 1, "R8 mixed");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule